// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into bytes. It detects a start bit and then samples every later bit at its centre, using a 16x oversample tick supplied from outside. It takes 7 or 8 data bits, least significant bit first. A parity bit, even or odd, may follow the data, and the frame ends with one or two stop bits. The frame format and the receive enable come in on input pins.

A host reaches the result through a small register port with a one-bit select. Select 0 is the received data, which is read only. Select 1 is the status register. Status bit 0 is the receive-full flag. Status bit 1 is the framing-error flag and status bit 2 is the parity-error flag. The two error flags are sticky, and while either of them is set the receiver accepts no new frame. The host clears an error flag in two steps: it first reads the status register and sees the flag at 1, then it writes 0 to that flag.

Top module: `async_rx`

## Requirements
- R1: A low level on the line starts a frame only if the line is still low at the start-bit centre, 8 ticks after the low was first seen. A shorter low pulse is ignored: no flag changes and no data is loaded.
- R2: Data bits are sampled once every 16 ticks at the bit centre, least significant bit first. With `cfgEightBits`=1 there are 8 data bits. With `cfgEightBits`=0 there are 7, and bit 7 of the data register reads 0.
- R3: With `cfgParityOn`=1, a parity bit follows the data. The parity-error flag (status bit 2) is set when the number of ones in the data plus the parity bit is odd while `cfgParityOdd`=0, or even while `cfgParityOdd`=1. With `cfgParityOn`=0 the parity-error flag is never set.
- R4: The framing-error flag (status bit 1) is set at the end of the frame when the first stop bit is sampled as 0.
- R5: With `cfgTwoStop`=1, the second stop bit is not checked. A 0 there sets no flag and does not stop the frame from being accepted.
- R6: A frame with a framing or parity error still loads the data register, but it does not set the receive-full flag.
- R7: While either error flag is 1, no new frame is received: the data register and the full flag stay unchanged. Reception resumes once both flags are clear.
- R8: Writing to select 1 with `regWdata` bit 0 = 0 clears the framing flag, and with bit 1 = 0 clears the parity flag. The write clears a flag only if the status register was read with that flag at 1 since the flag was last set. A write of 1 leaves the flag unchanged.
- R9: With `rxEnable`=0, any frame in progress is abandoned, no frame is received, and both error flags keep their values.
- R10: After reset, the status register and the data register read 0.
- R11: A frame without error loads the data register and sets the receive-full flag (status bit 0). A read of select 0 clears the full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample tick, 16 per bit time |
| rxLine | input | 1 | Serial input, idle high |
| rxEnable | input | 1 | Receive enable |
| cfgEightBits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityOn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgTwoStop | input | 1 | Two stop bits |
| regSel | input | 1 | 0: data register, 1: status register |
| regRd | input | 1 | Read strobe for the selected register |
| regWr | input | 1 | Write strobe (status register only) |
| regWdata | input | 2 | Write value: bit 0 framing flag, bit 1 parity flag |
| regRdata | output | 8 | Read value of the selected register |

## Verification
The bench sends a short low glitch. A receiver that does not check the start bit at its centre would instead report an all-ones byte as full. It sends frames with an error and then a second, clean frame while the error is still pending. A design that does not stall would overwrite the data register or raise the full flag. The clear sequence is driven in three ways: a write of 0 with no prior read, a write of 1 after a read, and a write of 0 after a read. A flag that clears on any write of 0 shows up after the first of these. A low second stop bit, and a bad parity bit sent while parity is off, catch a receiver that checks bits it should ignore.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  // strobes from control to datapath, one cycle wide, aligned to a tick
  typedef struct packed {
    logic sampleData;
    logic sampleParity;
    logic commit;
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_STOP2
  } rxState_t;

  localparam logic SEL_DATA   = 1'b0;
  localparam logic SEL_STATUS = 1'b1;

  // status register bit positions
  localparam int STAT_FULL   = 0;
  localparam int STAT_FRAME  = 1;
  localparam int STAT_PARITY = 2;

  // write-clear bit positions in regWdata
  localparam int WCLR_FRAME  = 0;
  localparam int WCLR_PARITY = 1;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxEnable,
  input  logic       cfgEightBits,
  input  logic       cfgParityOn,
  input  logic       cfgParityOdd,
  input  logic       cfgTwoStop,
  input  logic       lineBit,
  input  logic       stall,
  output rxStrobes_t strobes,
  output logic       frameEight,
  output logic       frameParOn,
  output logic       frameParOdd
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int IDX_W = $clog2(MAX_BITS + 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] nBits;
  logic             frameTwoStop;
  logic             lastTick;

  // format is latched at start detection so a mid-frame change is harmless
  assign nBits    = frameEight ? IDX_W'(MAX_BITS) : IDX_W'(MAX_BITS - 1);
  assign lastTick = tick && (tickCnt == CNT_W'(OVERSAMPLE - 1));

  always_comb begin
    strobes              = '0;
    strobes.sampleData   = rxEnable && (state == ST_DATA)   && lastTick;
    strobes.sampleParity = rxEnable && (state == ST_PARITY) && lastTick;
    strobes.commit       = rxEnable && (state == ST_STOP)   && lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      tickCnt      <= '0;
      bitIdx       <= '0;
      frameEight   <= 1'b0;
      frameParOn   <= 1'b0;
      frameParOdd  <= 1'b0;
      frameTwoStop <= 1'b0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tick && !lineBit && !stall) begin
            state        <= ST_START;
            tickCnt      <= '0;
            frameEight   <= cfgEightBits;
            frameParOn   <= cfgParityOn;
            frameParOdd  <= cfgParityOdd;
            frameTwoStop <= cfgTwoStop;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == CNT_W'(HALF - 1)) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= lineBit ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (bitIdx == nBits - 1'b1) begin
              state <= frameParOn ? ST_PARITY : ST_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (lastTick) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (lastTick) begin
            tickCnt <= '0;
            state   <= frameTwoStop ? ST_STOP2 : ST_IDLE;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP2: begin
          // second stop bit is waited out but never examined
          if (lastTick) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          tickCnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int MAX_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobes_t          strobes,
  input  logic                frameEight,
  input  logic                frameParOn,
  input  logic                frameParOdd,
  input  logic                regSel,
  input  logic                regRd,
  input  logic                regWr,
  input  logic [1:0]          regWdata,
  output logic                lineBit,
  output logic                stall,
  output logic                fullFlag,
  output logic                framingFlag,
  output logic                parityFlag,
  output logic [MAX_BITS-1:0] regRdata
);

  // SYNC_STAGES must be at least 2
  logic [SYNC_STAGES-1:0] syncQ;
  logic [MAX_BITS-1:0]    shiftReg;
  logic [MAX_BITS-1:0]    dataReg;
  logic [MAX_BITS-1:0]    frameData;
  logic                   parBit;
  logic                   parMiss;
  logic                   stopBad;
  logic                   armFrame;
  logic                   armParity;
  logic                   statusRead;
  logic                   dataRead;
  logic                   statusWrite;

  assign lineBit = syncQ[SYNC_STAGES-1];
  assign stall   = framingFlag | parityFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end

  // bits enter at the top, so after a short frame the data sits one place high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobes.sampleData)   shiftReg <= {lineBit, shiftReg[MAX_BITS-1:1]};
      if (strobes.sampleParity) parBit   <= lineBit;
    end
  end

  assign frameData = frameEight ? shiftReg : {1'b0, shiftReg[MAX_BITS-1:1]};
  assign parMiss   = frameParOn && (((^frameData) ^ parBit) != frameParOdd);
  assign stopBad   = !lineBit;

  assign statusRead  = regRd && (regSel == SEL_STATUS);
  assign dataRead    = regRd && (regSel == SEL_DATA);
  assign statusWrite = regWr && (regSel == SEL_STATUS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg     <= '0;
      fullFlag    <= 1'b0;
      framingFlag <= 1'b0;
      parityFlag  <= 1'b0;
      armFrame    <= 1'b0;
      armParity   <= 1'b0;
    end else begin
      if (dataRead) fullFlag <= 1'b0;

      if (statusWrite && !regWdata[WCLR_FRAME] && armFrame) begin
        framingFlag <= 1'b0;
        armFrame    <= 1'b0;
      end else if (statusRead && framingFlag) begin
        armFrame <= 1'b1;
      end

      if (statusWrite && !regWdata[WCLR_PARITY] && armParity) begin
        parityFlag <= 1'b0;
        armParity  <= 1'b0;
      end else if (statusRead && parityFlag) begin
        armParity <= 1'b1;
      end

      if (strobes.commit) begin
        dataReg <= frameData;
        if (!parMiss && !stopBad) fullFlag    <= 1'b1;
        if (stopBad)              framingFlag <= 1'b1;
        if (parMiss)              parityFlag  <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regSel == SEL_DATA) begin
      regRdata = dataReg;
    end else begin
      regRdata[STAT_FULL]   = fullFlag;
      regRdata[STAT_FRAME]  = framingFlag;
      regRdata[STAT_PARITY] = parityFlag;
    end
  end

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int MAX_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxLine,
  input  logic                rxEnable,
  input  logic                cfgEightBits,
  input  logic                cfgParityOn,
  input  logic                cfgParityOdd,
  input  logic                cfgTwoStop,
  input  logic                regSel,
  input  logic                regRd,
  input  logic                regWr,
  input  logic [1:0]          regWdata,
  output logic [MAX_BITS-1:0] regRdata
);

  rxStrobes_t strobes;
  logic       lineBit;
  logic       stall;
  logic       frameEight;
  logic       frameParOn;
  logic       frameParOdd;
  logic       fullFlag;
  logic       framingFlag;
  logic       parityFlag;

  async_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .MAX_BITS   (MAX_BITS)
  ) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick16),
    .rxEnable     (rxEnable),
    .cfgEightBits (cfgEightBits),
    .cfgParityOn  (cfgParityOn),
    .cfgParityOdd (cfgParityOdd),
    .cfgTwoStop   (cfgTwoStop),
    .lineBit      (lineBit),
    .stall        (stall),
    .strobes      (strobes),
    .frameEight   (frameEight),
    .frameParOn   (frameParOn),
    .frameParOdd  (frameParOdd)
  );

  async_rx_dp #(
    .MAX_BITS    (MAX_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .strobes     (strobes),
    .frameEight  (frameEight),
    .frameParOn  (frameParOn),
    .frameParOdd (frameParOdd),
    .regSel      (regSel),
    .regRd       (regRd),
    .regWr       (regWr),
    .regWdata    (regWdata),
    .lineBit     (lineBit),
    .stall       (stall),
    .fullFlag    (fullFlag),
    .framingFlag (framingFlag),
    .parityFlag  (parityFlag),
    .regRdata    (regRdata)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk
  import async_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       regSel,
  input logic       regWr,
  input logic [1:0] regWdata,
  input logic       fullFlag,
  input logic       framingFlag,
  input logic       parityFlag,
  input logic       commit,
  input logic       frameParOn
);

  assert_full_only_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> ($past(commit) && !framingFlag && !parityFlag));

  assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (framingFlag && !(regWr && regSel == SEL_STATUS && !regWdata[WCLR_FRAME]))
      |=> framingFlag);

  assert_parity_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (parityFlag && !(regWr && regSel == SEL_STATUS && !regWdata[WCLR_PARITY]))
      |=> parityFlag);

  assert_frame_set_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(framingFlag) |-> $past(commit));

  assert_no_parity_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityFlag) |-> ($past(commit) && $past(frameParOn)));

  assert_stall_on_error_R7: assert property (@(posedge clk) disable iff (!rstN)
    (framingFlag || parityFlag) |-> !commit);

  assert_disabled_no_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !commit);

endmodule

bind async_rx async_rx_chk chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxEnable    (rxEnable),
  .regSel      (regSel),
  .regWr       (regWr),
  .regWdata    (regWdata),
  .fullFlag    (fullFlag),
  .framingFlag (framingFlag),
  .parityFlag  (parityFlag),
  .commit      (strobes.commit),
  .frameParOn  (frameParOn)
);

// File: tb/async_rx_test.sv
module async_rx_test;

  localparam int TICK_DIV = 3;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b1;
  logic       cfgEightBits = 1'b1;
  logic       cfgParityOn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic       regSel = 1'b0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regWdata = 2'b11;
  logic [7:0] regRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] divCnt;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= (divCnt == 2'(TICK_DIV - 1)) ? 2'd0 : divCnt + 2'd1;
  end
  assign tick16 = (divCnt == 2'(TICK_DIV - 1));

  async_rx uut (
    .clk          (clk),
    .rstN         (rstN),
    .tick16       (tick16),
    .rxLine       (rxLine),
    .rxEnable     (rxEnable),
    .cfgEightBits (cfgEightBits),
    .cfgParityOn  (cfgParityOn),
    .cfgParityOdd (cfgParityOdd),
    .cfgTwoStop   (cfgTwoStop),
    .regSel       (regSel),
    .regRd        (regRd),
    .regWr        (regWr),
    .regWdata     (regWdata),
    .regRdata     (regRdata)
  );

  typedef struct packed {
    logic [7:0] data;
    logic eight, parOn, parOdd, two, badPar, badStop, badStop2;
    logic expFull, expFe, expPe;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0},  // R11 R2 8-bit clean
    '{8'hBC, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0},  // R2 7-bit, reads 3C
    '{8'h5A, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0},  // R3 even good
    '{8'h5A, 1, 1, 1, 0, 0, 0, 0, 1, 0, 0},  // R3 odd good
    '{8'h5B, 1, 1, 0, 0, 1, 0, 0, 0, 0, 1},  // R3 R6 even bad
    '{8'h81, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0},  // R4 R6 stop low
    '{8'h0F, 1, 0, 0, 1, 0, 0, 1, 1, 0, 0},  // R5 second stop low
    '{8'h70, 1, 1, 1, 0, 1, 1, 0, 0, 1, 1},  // R3 R4 both errors
    '{8'h55, 0, 1, 1, 1, 0, 0, 0, 1, 0, 0},  // R2 7-bit odd two stops
    '{8'h33, 1, 0, 0, 0, 1, 0, 0, 1, 0, 0}   // R3 parity off, no flag
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    @(negedge clk);
    rxLine = v;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input vec_t v);
    logic [7:0] d;
    int n;
    n = v.eight ? 8 : 7;
    d = v.eight ? v.data : {1'b0, v.data[6:0]};
    cfgEightBits = v.eight;
    cfgParityOn  = v.parOn;
    cfgParityOdd = v.parOdd;
    cfgTwoStop   = v.two;
    sendBit(1'b0);
    for (int i = 0; i < n; i++) sendBit(d[i]);
    if (v.parOn) sendBit((^d) ^ v.parOdd ^ v.badPar);
    else if (v.badPar) begin end
    sendBit(!v.badStop);
    if (v.two) sendBit(!v.badStop2);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel;
    regRd  = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] val);
    @(negedge clk);
    regSel   = 1'b1;
    regWdata = val;
    regWr    = 1'b1;
    @(negedge clk);
    regWr    = 1'b0;
    regWdata = 2'b11;
  endtask

  task automatic clearFlags();
    logic [7:0] s;
    readReg(1'b1, s);
    writeReg(2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [7:0] dv;
    vec_t g;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    readReg(1'b1, st); check("R10 status after reset", st, 8'h00);
    readReg(1'b0, dv); check("R10 data after reset", dv, 8'h00);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      sendFrame(VECS[k]);
      readReg(1'b1, st);
      check($sformatf("vec %0d status (R3 R4 R5 R6 R11)", k), st,
            {5'b0, VECS[k].expPe, VECS[k].expFe, VECS[k].expFull});
      readReg(1'b0, dv);
      check($sformatf("vec %0d data (R2 R6)", k), dv,
            VECS[k].eight ? VECS[k].data : {1'b0, VECS[k].data[6:0]});
      readReg(1'b1, st);
      check($sformatf("vec %0d full cleared by data read R11", k), st & 8'h01, 8'h00);
      clearFlags();
      readReg(1'b1, st);
      check($sformatf("vec %0d flags cleared R8", k), st, 8'h00);
    end

    // R1: short low glitch is ignored
    cfgEightBits = 1; cfgParityOn = 0; cfgTwoStop = 0;
    @(negedge clk); rxLine = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    readReg(1'b1, st); check("R1 glitch leaves status", st, 8'h00);
    readReg(1'b0, dv); check("R1 glitch leaves data", dv, 8'h33);

    // R8 and R7: stall and clear sequence
    g = '{8'h11, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0};
    sendFrame(g);
    writeReg(2'b00);  // no prior read: must not clear
    readReg(1'b1, st); check("R8 write 0 without read keeps flag", st, 8'h02);
    g = '{8'h22, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0};
    sendFrame(g);
    readReg(1'b0, dv); check("R7 data held while stalled", dv, 8'h11);
    readReg(1'b1, st); check("R7 full not set while stalled", st, 8'h02);
    writeReg(2'b11);
    readReg(1'b1, st); check("R8 write 1 has no effect", st, 8'h02);
    writeReg(2'b00);
    readReg(1'b1, st); check("R8 write 0 after read clears", st, 8'h00);
    sendFrame(g);
    readReg(1'b1, st); check("R7 reception resumes", st, 8'h01);
    readReg(1'b0, dv); check("R7 resumed data", dv, 8'h22);

    // R9: disabling keeps flags
    g = '{8'h5B, 1, 1, 0, 0, 1, 0, 0, 0, 0, 1};
    sendFrame(g);
    @(negedge clk); rxEnable = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);
    readReg(1'b1, st); check("R9 flags kept with enable low", st, 8'h04);
    rxEnable = 1'b1;
    clearFlags();

    // R9: frame abandoned when enable drops mid-frame
    sendBit(1'b0);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    @(negedge clk); rxEnable = 1'b0;
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    @(negedge clk); rxEnable = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    readReg(1'b1, st); check("R9 aborted frame sets nothing", st, 8'h00);
    readReg(1'b0, dv); check("R9 aborted frame leaves data", dv, 8'h5B);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule